// File: doc/BRIEF.md
# Pixel-Patch Isolation Sorter

This block takes the occupied pixel patches of one event from one sensor. Each patch is four pixels by two and carries an 8-bit hit map with a 6-bit column and 6-bit row address on a 64 by 64 patch grid. It buffers the event's patches until an end-of-event strobe arrives. It then decides for each patch whether any of the eight patch positions around it holds an active patch.

A patch with no active neighbour is isolated. Its cluster coordinate is read from a 256-entry table indexed by the hit map and sent on the isolated stream. A patch with at least one active neighbour is passed unchanged on the neighbour stream, for a later multi-patch clustering stage. The table is written through a plain write port before traffic starts. Results leave one per cycle, in arrival order. While results are leaving, the input is not ready.

Top module: `sp_isolation_router`

## Requirements
- R1: A patch whose hit map is 8'h00 is not stored, never appears on either output, and does not count as a neighbour of any other patch.
- R2: A patch with no stored active patch at column and row distance of at most 1 appears on the isolated stream (`iso_valid`=1) with its column, its row and `iso_coord` equal to the table entry at the index given by its hit map.
- R3: A patch with an active patch at horizontal or vertical distance 1 appears on the neighbour stream (`nbr_valid`=1) with its column, row and hit map unchanged. The two valid outputs are never high in the same cycle.
- R4: A patch that touches another only at a corner (both distances 1) counts as a neighbour.
- R5: Patches two positions apart in column or row are not neighbours.
- R6: Addresses do not wrap at the grid edge: column 0 and column 63 are not adjacent, and neither are row 0 and row 63.
- R7: No result appears before the end-of-event strobe. With `in_eoe` sampled at clock edge E, the first result is registered at edge E+1 and each further result one edge later, in arrival order.
- R8: `in_ready` is low from edge E until the last result of the event is registered, and input offered meanwhile is ignored.
- R9: While reset is applied, both valid outputs are 0 and `in_ready` is 1.
- R10: A table write at one edge is seen by every isolated result registered after that edge.
- R11: At most DEPTH patches (default 16) are kept per event. Further patches in the same event are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Patch present on the input |
| in_col | input | 6 | Patch column |
| in_row | input | 6 | Patch row |
| in_hits | input | 8 | Patch hit map |
| in_eoe | input | 1 | End-of-event strobe |
| in_ready | output | 1 | Block accepts patches and strobes |
| lut_we | input | 1 | Table write enable |
| lut_addr | input | 8 | Table write index (hit map) |
| lut_wdata | input | COORD_W | Table write data |
| iso_valid | output | 1 | Isolated result valid |
| iso_col | output | 6 | Isolated patch column |
| iso_row | output | 6 | Isolated patch row |
| iso_coord | output | COORD_W | Table coordinate for the isolated patch |
| nbr_valid | output | 1 | Neighbour-stream result valid |
| nbr_col | output | 6 | Forwarded patch column |
| nbr_row | output | 6 | Forwarded patch row |
| nbr_hits | output | 8 | Forwarded patch hit map |

## Verification
The first result of an event is due one edge after the edge that samples the end-of-event strobe. The other results follow at one per edge, so an event of N stored patches finishes N edges after the strobe. The bench samples on falling edges. It records every valid output with its stream and fields, and it compares the records in arrival order only after N plus a few cycles have passed. The latency itself is checked directly: at the falling edge just after the strobe edge no result may be present and `in_ready` must be low, and at the following falling edge the first result must be present.

// File: rtl/sp_pkg.sv
// Shared widths and the patch record used across the isolation sorter.
// Assumes a square-ish grid addressed by plain binary column and row.
package sp_pkg;
    localparam int COL_W = 6;
    localparam int ROW_W = 6;
    localparam int HIT_W = 8;

    typedef struct packed {
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
        logic [HIT_W-1:0] hits;
    } sp_t;
endpackage

// File: rtl/sp_event_store.sv
// Holds the active patches of one event in arrival order.
// Assumes the caller only raises wr_en for nonzero hit maps; writes beyond
// DEPTH are discarded. clr empties the store for the next event.
module sp_event_store
    import sp_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  sp_t              wr_sp,
    input  logic             clr,
    output logic [CNT_W-1:0] count,
    output sp_t              ent [DEPTH]
);
    logic room;
    assign room = (count < CNT_W'(DEPTH));

    // Fill level: grows on accepted writes, cleared at end of emission.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            count <= '0;
        else if (wr_en && room)
            count <= count + 1'b1;
    end

    // One slot per entry, written when the fill level points at it.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && room && count == CNT_W'(g))
                ent[g] <= wr_sp;
        end
    end

    assert_count_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    assert_full_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_W'(DEPTH) && !clr) |=> count == CNT_W'(DEPTH));
endmodule

// File: rtl/sp_neighbour_test.sv
// Decides whether the patch under test has any stored patch within one
// position in both column and row. Differences are taken one bit wider than
// the address, so the grid edges never wrap. Purely combinational.
module sp_neighbour_test
    import sp_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  sp_t              ent [DEPTH],
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] sel,
    input  sp_t              cur,
    output logic             isolated
);
    logic [DEPTH-1:0] near;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        logic [COL_W:0] dc;
        logic [ROW_W:0] dr;
        logic           col_adj, row_adj;
        // Signed distance to entry g, then within-one test on each axis.
        always_comb begin
            dc      = {1'b0, ent[g].col} - {1'b0, cur.col};
            dr      = {1'b0, ent[g].row} - {1'b0, cur.row};
            col_adj = (dc == '0) || (dc == (COL_W+1)'(1)) || (dc == '1);
            row_adj = (dr == '0) || (dr == (ROW_W+1)'(1)) || (dr == '1);
            near[g] = (CNT_W'(g) < count) && (CNT_W'(g) != sel) && col_adj && row_adj;
        end
    end

    assign isolated = ~|near;
endmodule

// File: rtl/sp_decode_lut.sv
// Hit-map to cluster-coordinate table, 256 entries, written one entry per
// cycle through a plain port and read combinationally. No reset: contents
// are expected to be loaded before traffic.
module sp_decode_lut
    import sp_pkg::*;
#(
    parameter int COORD_W = 8,
    localparam int ENTRIES = 1 << HIT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [HIT_W-1:0]   waddr,
    input  logic [COORD_W-1:0] wdata,
    input  logic [HIT_W-1:0]   raddr,
    output logic [COORD_W-1:0] rdata
);
    logic [COORD_W-1:0] table_q [ENTRIES];

    // Table write port.
    always_ff @(posedge clk) begin
        if (we)
            table_q[waddr] <= wdata;
    end

    assign rdata = table_q[raddr];

    assert_lut_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> table_q[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/sp_isolation_router.sv
// Buffers one event of pixel patches, then emits each stored patch once per
// cycle: isolated ones with their table coordinate, the rest unchanged on the
// neighbour stream. Assumes unique patch addresses within an event and that
// the source holds traffic while in_ready is low.
module sp_isolation_router
    import sp_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int COORD_W = 8,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [COL_W-1:0]   in_col,
    input  logic [ROW_W-1:0]   in_row,
    input  logic [HIT_W-1:0]   in_hits,
    input  logic               in_eoe,
    output logic               in_ready,
    input  logic               lut_we,
    input  logic [HIT_W-1:0]   lut_addr,
    input  logic [COORD_W-1:0] lut_wdata,
    output logic               iso_valid,
    output logic [COL_W-1:0]   iso_col,
    output logic [ROW_W-1:0]   iso_row,
    output logic [COORD_W-1:0] iso_coord,
    output logic               nbr_valid,
    output logic [COL_W-1:0]   nbr_col,
    output logic [ROW_W-1:0]   nbr_row,
    output logic [HIT_W-1:0]   nbr_hits
);
    typedef enum logic {ST_COLLECT, ST_EMIT} state_t;

    state_t             state;
    logic [CNT_W-1:0]   count, idx;
    sp_t                ent [DEPTH];
    sp_t                cur, wr_sp;
    logic               wr_en, emit_act, last, isolated;
    logic [COORD_W-1:0] coord;

    assign in_ready = (state == ST_COLLECT);
    assign wr_sp    = '{col: in_col, row: in_row, hits: in_hits};
    assign wr_en    = in_ready && in_valid && (in_hits != '0);
    assign emit_act = (state == ST_EMIT) && (idx < count);
    assign last     = (state == ST_EMIT) && (idx + 1'b1 >= count);
    assign cur      = ent[idx[IDX_W-1:0]];

    sp_event_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sp(wr_sp),
        .clr(last), .count(count), .ent(ent)
    );

    sp_neighbour_test #(.DEPTH(DEPTH)) u_nbr (
        .ent(ent), .count(count), .sel(idx), .cur(cur), .isolated(isolated)
    );

    sp_decode_lut #(.COORD_W(COORD_W)) u_lut (
        .clk(clk), .rst_n(rst_n), .we(lut_we), .waddr(lut_addr),
        .wdata(lut_wdata), .raddr(cur.hits), .rdata(coord)
    );

    // Phase control: collect until end of event, then walk the store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_COLLECT;
            idx   <= '0;
        end else if (state == ST_COLLECT) begin
            idx <= '0;
            if (in_eoe)
                state <= ST_EMIT;
        end else if (last) begin
            state <= ST_COLLECT;
            idx   <= '0;
        end else begin
            idx <= idx + 1'b1;
        end
    end

    // Output registers for both streams.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iso_valid <= 1'b0;
            nbr_valid <= 1'b0;
        end else begin
            iso_valid <= emit_act && isolated;
            nbr_valid <= emit_act && !isolated;
        end
        iso_col   <= cur.col;
        iso_row   <= cur.row;
        iso_coord <= coord;
        nbr_col   <= cur.col;
        nbr_row   <= cur.row;
        nbr_hits  <= cur.hits;
    end

    assert_one_stream_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(iso_valid && nbr_valid));
    assert_no_empty_fwd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        nbr_valid |-> nbr_hits != '0);
    assert_emit_after_eoe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_EMIT) |-> $past(in_eoe));
    assert_result_from_emit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (iso_valid || nbr_valid) |-> $past(state == ST_EMIT));
    assert_ready_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && !last) |=> !in_ready);
endmodule

// File: tb/sp_isolation_router_bench.sv
module sp_isolation_router_bench;
    localparam int DEPTH = 16;
    localparam int CW    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_eoe = 1'b0, lut_we = 1'b0;
    logic [5:0] in_col = '0, in_row = '0;
    logic [7:0] in_hits = '0, lut_addr = '0;
    logic [CW-1:0] lut_wdata = '0;
    logic in_ready, iso_valid, nbr_valid;
    logic [5:0] iso_col, iso_row, nbr_col, nbr_row;
    logic [CW-1:0] iso_coord;
    logic [7:0] nbr_hits;

    always #4 clk = ~clk;

    sp_isolation_router #(.DEPTH(DEPTH), .COORD_W(CW)) u_sp_isolation_router (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_col(in_col),
        .in_row(in_row), .in_hits(in_hits), .in_eoe(in_eoe), .in_ready(in_ready),
        .lut_we(lut_we), .lut_addr(lut_addr), .lut_wdata(lut_wdata),
        .iso_valid(iso_valid), .iso_col(iso_col), .iso_row(iso_row),
        .iso_coord(iso_coord), .nbr_valid(nbr_valid), .nbr_col(nbr_col),
        .nbr_row(nbr_row), .nbr_hits(nbr_hits)
    );

    int n_run = 0, n_fail = 0;

    function automatic logic [7:0] ref_lut(input logic [7:0] h);
        return {h[3:0], h[7:4]} ^ 8'hA5;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Result recorder, sampled on falling edges.
    int   cap_n = 0;
    logic cap_iso [64];
    logic [5:0] cap_col [64];
    logic [5:0] cap_row [64];
    logic [7:0] cap_dat [64];
    always @(negedge clk) begin
        if ((iso_valid || nbr_valid) && cap_n < 64) begin
            cap_iso[cap_n] = iso_valid;
            cap_col[cap_n] = iso_valid ? iso_col : nbr_col;
            cap_row[cap_n] = iso_valid ? iso_row : nbr_row;
            cap_dat[cap_n] = iso_valid ? iso_coord : nbr_hits;
            cap_n = cap_n + 1;
        end
    end

    typedef struct packed {
        logic [5:0] c;
        logic [5:0] r;
        logic [7:0] h;
        logic       iso;
    } vec_t;

    // One event: col, row, hit map, expected isolated flag.
    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{6'd10, 6'd10, 8'h01, 1'b0},  // R4 corner pair
        '{6'd11, 6'd11, 8'h80, 1'b0},
        '{6'd20, 6'd20, 8'h3C, 1'b1},  // R5 two apart
        '{6'd22, 6'd20, 8'h01, 1'b1},
        '{6'd30, 6'd5,  8'h00, 1'b0},  // R1 empty, dropped
        '{6'd29, 6'd5,  8'hFF, 1'b1},  // R1 empty does not count
        '{6'd0,  6'd0,  8'h11, 1'b1},  // R6 corners, no wrap
        '{6'd63, 6'd63, 8'h22, 1'b1},
        '{6'd63, 6'd0,  8'h44, 1'b1},
        '{6'd0,  6'd63, 8'h88, 1'b1},
        '{6'd40, 6'd40, 8'h0F, 1'b0},  // R3 vertical pair
        '{6'd40, 6'd41, 8'hF0, 1'b0},
        '{6'd50, 6'd50, 8'h02, 1'b0},  // R3 horizontal pair
        '{6'd51, 6'd50, 8'h40, 1'b0}
    };

    task automatic send(input logic [5:0] c, input logic [5:0] r, input logic [7:0] h);
        @(negedge clk);
        in_valid = 1'b1; in_col = c; in_row = r; in_hits = h;
    endtask

    task automatic end_event();
        @(negedge clk);
        in_valid = 1'b0; in_eoe = 1'b1;
        @(negedge clk);
        in_eoe = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int base, k;
        // R9 reset state
        repeat (3) @(negedge clk);
        check(!iso_valid && !nbr_valid, "R9 valids in reset", {iso_valid, nbr_valid}, 0);
        check(in_ready === 1'b1, "R9 ready in reset", in_ready, 1);
        // Load table from the bench reference.
        for (int a = 0; a < 256; a++) begin
            @(negedge clk);
            lut_we = 1'b1; lut_addr = 8'(a); lut_wdata = ref_lut(8'(a));
        end
        @(negedge clk);
        lut_we = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // Vector walk.
        base = cap_n;
        for (int i = 0; i < NV; i++) send(VEC[i].c, VEC[i].r, VEC[i].h);
        @(negedge clk);
        in_valid = 1'b0;
        check(cap_n == base, "R7 nothing before end of event", cap_n - base, 0);
        end_event();
        repeat (DEPTH + 4) @(negedge clk);
        check(cap_n - base == NV - 1, "R1 result count", cap_n - base, NV - 1);
        k = base;
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].h != 8'h00) begin
                logic [7:0] ed;
                ed = VEC[i].iso ? ref_lut(VEC[i].h) : VEC[i].h;
                check(cap_iso[k] == VEC[i].iso, VEC[i].iso ? "R2 stream" : "R3 stream",
                      cap_iso[k], VEC[i].iso);
                check(cap_col[k] == VEC[i].c && cap_row[k] == VEC[i].r, "R7 order/address",
                      {cap_col[k], cap_row[k]}, {VEC[i].c, VEC[i].r});
                check(cap_dat[k] == ed, VEC[i].iso ? "R2 coord" : "R3 hits", cap_dat[k], ed);
                k++;
            end
        end

        // R7/R8 latency and ready, with ignored input during emission.
        base = cap_n;
        send(6'd5, 6'd5, 8'h3C);
        @(negedge clk);
        in_valid = 1'b0; in_eoe = 1'b1;
        @(negedge clk);
        in_eoe = 1'b0;
        check(!iso_valid && !nbr_valid, "R7 no result one edge after strobe", iso_valid, 0);
        check(in_ready == 1'b0, "R8 ready low during emission", in_ready, 0);
        in_valid = 1'b1; in_col = 6'd6; in_row = 6'd5; in_hits = 8'h01;
        @(negedge clk);
        in_valid = 1'b0;
        check(iso_valid == 1'b1, "R7 first result at E+1", iso_valid, 1);
        check(iso_coord == ref_lut(8'h3C), "R8 offered input ignored", iso_coord, ref_lut(8'h3C));
        repeat (4) @(negedge clk);
        check(cap_n - base == 1, "R8 single result", cap_n - base, 1);
        check(in_ready == 1'b1, "R8 ready back", in_ready, 1);

        // R10 table rewrite.
        @(negedge clk);
        lut_we = 1'b1; lut_addr = 8'h3C; lut_wdata = 8'h77;
        @(negedge clk);
        lut_we = 1'b0;
        base = cap_n;
        send(6'd5, 6'd5, 8'h3C);
        end_event();
        repeat (4) @(negedge clk);
        check(cap_n - base == 1 && cap_dat[base] == 8'h77, "R10 rewritten entry",
              cap_dat[base], 8'h77);

        // R11 overflow.
        base = cap_n;
        for (int i = 0; i < DEPTH + 2; i++) send(6'(2 * i), 6'd30, 8'h81);
        end_event();
        repeat (DEPTH + 4) @(negedge clk);
        check(cap_n - base == DEPTH, "R11 kept count", cap_n - base, DEPTH);
        check(cap_col[base + DEPTH - 1] == 6'(2 * (DEPTH - 1)), "R11 last kept",
              cap_col[base + DEPTH - 1], 2 * (DEPTH - 1));

        // R1 event of only empty maps produces nothing.
        base = cap_n;
        send(6'd1, 6'd1, 8'h00);
        end_event();
        repeat (4) @(negedge clk);
        check(cap_n == base && in_ready, "R1 empty event", cap_n - base, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule